// File: doc/BRIEF.md
# Single-Precision Min/Max and Compare Unit

This block evaluates one of eight two-operand operations on a pair of 32-bit IEEE-754 single-precision values and presents the outcome one clock later. Four of the operations pick the smaller or larger operand. They differ in how a NaN operand is handled: one pair ignores a lone NaN, the other pair spreads any NaN into the canonical NaN. The other four are ordered relations (less-than and less-or-equal), each in a signalling and a quiet form. A relation result is a single bit placed in bit 0 of the 32-bit result bus.

Alongside the result the unit drives a five-bit exception flag vector. Only the invalid-operation bit can ever be set. An integration issues one operation per cycle and takes the result and flags on the following cycle. It accumulates the flags elsewhere.

Top module: `fpmm_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `result` and `fflags` become zero on that edge.
- R2: `result` and `fflags` show the operation applied at the previous rising edge. A new operation can be issued every cycle.
- R3: The operation select is 000 min, 001 max, 010 NaN-propagating min, 011 NaN-propagating max, 100 less-or-equal, 101 less-than, 110 quiet less-or-equal, 111 quiet less-than.
- R4: Ordinary min/max (000, 001) return the canonical NaN 0x7FC00000 only when both operands are NaN. With exactly one NaN operand they return the other operand.
- R5: NaN-propagating min/max (010, 011) return 0x7FC00000 when either operand is NaN.
- R6: Without NaN operands, both min/max families return the same operand, ordered numerically, with -0.0 (0x80000000) below +0.0 (0x00000000).
- R7: Every min/max operation raises invalid exactly when an operand is a signalling NaN. A signalling NaN has an all-ones exponent, a nonzero mantissa, and mantissa bit 22 clear.
- R8: Every relation drives its truth in `result[0]` with bits 31:1 zero. Any NaN operand gives 0, and +0.0 and -0.0 compare equal.
- R9: The signalling relations (100, 101) raise invalid when either operand is any NaN.
- R10: The quiet relations (110, 111) raise invalid only when an operand is a signalling NaN.
- R11: The invalid flag is `fflags[4]`. `fflags[3:0]` are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 3 | Operation select |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| result | output | 32 | Registered min/max value or zero-extended relation bit |
| fflags | output | 5 | Registered exception flags; bit 4 is invalid |

## Verification
A value result and the invalid flag can fall in the same cycle. With a signalling NaN at a NaN-propagating max, the canonical NaN and the invalid bit both appear. With a quiet NaN at an ordinary min, the other operand comes out and the flag stays clear. The bench drives these pairs, plus relations on signalling and quiet NaNs. It judges `result` and `fflags` together in the cycle after issue against a model built on sortable integer keys. Back-to-back issues with different operations confirm that nothing carries over from one cycle to the next.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;
  typedef enum logic [2:0] {
    OP_MIN  = 3'd0,
    OP_MAX  = 3'd1,
    OP_MINP = 3'd2,
    OP_MAXP = 3'd3,
    OP_LE   = 3'd4,
    OP_LT   = 3'd5,
    OP_LEQ  = 3'd6,
    OP_LTQ  = 3'd7
  } fpmm_op_e;

  localparam int FLAG_W = 5;
  localparam int NV_BIT = 4;

  typedef struct packed {
    logic nan;
    logic snan;
    logic zero;
    logic sign;
  } fp_class_t;
endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify
  import fpmm_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] x,
  output fp_class_t            cls
);
  localparam int W = EXP_W + MAN_W + 1;

  logic exp_ones, exp_zero, man_zero;

  always_comb begin
    exp_ones = &x[W-2:MAN_W];
    exp_zero = ~|x[W-2:MAN_W];
    man_zero = ~|x[MAN_W-1:0];
    cls.sign = x[W-1];
    cls.zero = exp_zero & man_zero;
    cls.nan  = exp_ones & ~man_zero;
    cls.snan = exp_ones & ~man_zero & ~x[MAN_W-1];
  end
endmodule

// File: rtl/fpmm_order.sv
module fpmm_order
  import fpmm_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] a,
  input  logic [EXP_W+MAN_W:0] b,
  input  fp_class_t            ca,
  input  fp_class_t            cb,
  output logic                 lt_num,
  output logic                 eq_num,
  output logic                 lt_mm
);
  localparam int W = EXP_W + MAN_W + 1;

  logic [W-2:0] mag_a, mag_b;
  logic both_zero;

  always_comb begin
    mag_a     = a[W-2:0];
    mag_b     = b[W-2:0];
    both_zero = ca.zero & cb.zero;
    if (ca.sign != cb.sign)
      lt_num = ca.sign & ~both_zero;
    else if (!ca.sign)
      lt_num = mag_a < mag_b;
    else
      lt_num = mag_b < mag_a;
    eq_num = (a == b) | both_zero;
    lt_mm  = lt_num | (both_zero & ca.sign & ~cb.sign);
  end
endmodule

// File: rtl/fpmm_unit.sv
module fpmm_unit
  import fpmm_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [2:0]               op_sel,
  input  logic [EXP_W+MAN_W:0]     opa,
  input  logic [EXP_W+MAN_W:0]     opb,
  output logic [EXP_W+MAN_W:0]     result,
  output logic [FLAG_W-1:0]        fflags
);
  localparam int W = EXP_W + MAN_W + 1;
  localparam logic [W-1:0] CANON_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic [W-1:0] ops [2];
  fp_class_t    cls [2];

  assign ops[0] = opa;
  assign ops[1] = opb;

  for (genvar gi = 0; gi < 2; gi++) begin : g_cls
    fpmm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .x   (ops[gi]),
      .cls (cls[gi])
    );
  end

  logic lt_num, eq_num, lt_mm;

  fpmm_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_order (
    .a      (opa),
    .b      (opb),
    .ca     (cls[0]),
    .cb     (cls[1]),
    .lt_num (lt_num),
    .eq_num (eq_num),
    .lt_mm  (lt_mm)
  );

  logic any_nan, both_nan, any_snan;
  logic [W-1:0] res_d;
  logic         nv_d;
  fpmm_op_e     op;

  always_comb begin
    op       = fpmm_op_e'(op_sel);
    any_nan  = cls[0].nan | cls[1].nan;
    both_nan = cls[0].nan & cls[1].nan;
    any_snan = cls[0].snan | cls[1].snan;
    res_d    = '0;
    nv_d     = 1'b0;
    unique case (op)
      OP_MIN, OP_MAX, OP_MINP, OP_MAXP: begin
        nv_d = any_snan;
        if (both_nan || ((op == OP_MINP || op == OP_MAXP) && any_nan))
          res_d = CANON_NAN;
        else if (cls[0].nan)
          res_d = opb;
        else if (cls[1].nan)
          res_d = opa;
        else if (op == OP_MIN || op == OP_MINP)
          res_d = lt_mm ? opa : opb;
        else
          res_d = lt_mm ? opb : opa;
      end
      default: begin
        nv_d     = (op == OP_LEQ || op == OP_LTQ) ? any_snan : any_nan;
        res_d[0] = ~any_nan & ((op == OP_LT || op == OP_LTQ) ? lt_num : (lt_num | eq_num));
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      fflags <= '0;
    end else begin
      result         <= res_d;
      fflags         <= '0;
      fflags[NV_BIT] <= nv_d;
    end
  end
endmodule

// File: rtl/fpmm_unit_chk.sv
module fpmm_unit_chk
  import fpmm_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input logic                 clk,
  input logic                 rst,
  input logic [2:0]           op_sel,
  input logic [EXP_W+MAN_W:0] opa,
  input logic [EXP_W+MAN_W:0] opb,
  input logic [EXP_W+MAN_W:0] result,
  input logic [FLAG_W-1:0]    fflags
);
  localparam int W = EXP_W + MAN_W + 1;
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  logic a_nan, b_nan, a_snan, b_snan;
  assign a_nan  = (&opa[W-2:MAN_W]) && (|opa[MAN_W-1:0]);
  assign b_nan  = (&opb[W-2:MAN_W]) && (|opb[MAN_W-1:0]);
  assign a_snan = a_nan && !opa[MAN_W-1];
  assign b_snan = b_nan && !opb[MAN_W-1];

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (result == '0 && fflags == '0));

  p_only_nv_r11: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> fflags[3:0] == 4'b0);

  p_both_nan_canon_r4: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(op_sel[2:1] == 2'b00 && a_nan && b_nan) |-> result == QNAN);

  p_prop_nan_r5: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(op_sel[2:1] == 2'b01 && (a_nan || b_nan)) |-> result == QNAN);

  p_cmp_ext_r8: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(op_sel[2]) |-> result[W-1:1] == '0);

  p_cmp_nan_zero_r8: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(op_sel[2] && (a_nan || b_nan)) |-> result == '0);

  p_quiet_nv_r10: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(op_sel[2:1] == 2'b11 && !a_snan && !b_snan) |-> !fflags[NV_BIT]);

  p_sig_nv_r9: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(op_sel[2:1] == 2'b10 && (a_nan || b_nan)) |-> fflags[NV_BIT]);

  p_mm_nv_r7: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(!op_sel[2]) |-> fflags[NV_BIT] == $past(a_snan || b_snan));
endmodule

bind fpmm_unit fpmm_unit_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (.*);

// File: tb/test_fpmm_unit.sv
module test_fpmm_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_sel = 3'd0;
  logic [31:0] opa = '0, opb = '0;
  logic [31:0] result;
  logic [4:0]  fflags;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  fpmm_unit i_fpmm_unit (
    .clk(clk), .rst(rst), .op_sel(op_sel), .opa(opa), .opb(opb),
    .result(result), .fflags(fflags)
  );

  localparam logic [31:0] P1 = 32'h3F800000, P2 = 32'h40000000;
  localparam logic [31:0] N1 = 32'hBF800000, N2 = 32'hC0000000;
  localparam logic [31:0] PZ = 32'h00000000, NZ = 32'h80000000;
  localparam logic [31:0] QN = 32'h7FC00000, QN2 = 32'hFFC12345;
  localparam logic [31:0] SN = 32'h7F800001, PINF = 32'h7F800000, NINF = 32'hFF800000;

  function automatic logic [31:0] key(input logic [31:0] v);
    return v[31] ? ~v : (v | 32'h80000000);
  endfunction

  function automatic logic is_nan(input logic [31:0] v);
    return v[30:23] == 8'hFF && v[22:0] != 0;
  endfunction

  function automatic logic [36:0] model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r; logic nv; logic an, bn, sa, sb, zz;
    an = is_nan(a); bn = is_nan(b);
    sa = an && !a[22]; sb = bn && !b[22];
    zz = (a[30:0] == 0) && (b[30:0] == 0);
    r = '0; nv = 1'b0;
    if (!op[2]) begin
      nv = sa || sb;
      if ((op[1] && (an || bn)) || (an && bn)) r = 32'h7FC00000;
      else if (an) r = b;
      else if (bn) r = a;
      else if (!op[0]) r = (key(a) <= key(b)) ? a : b;
      else r = (key(a) >= key(b)) ? a : b;
    end else begin
      nv = op[1] ? (sa || sb) : (an || bn);
      if (an || bn) r = 0;
      else if (zz) r = {31'b0, !op[0]};
      else r = {31'b0, op[0] ? key(a) < key(b) : key(a) <= key(b)};
    end
    return {nv, 4'b0, r};
  endfunction

  task automatic check(input string tag, input logic [36:0] got, input logic [36:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got result=%h flags=%b, expected result=%h flags=%b",
               tag, got[31:0], got[36:32], exp[31:0], exp[36:32]);
    end
  endtask

  task automatic step(input string tag, input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_sel = op; opa = a; opb = b;
    @(posedge clk);
    #1;
    check(tag, {fflags, result}, model(op, a, b));
  endtask

  task automatic t_reset;
    @(negedge clk);
    op_sel = 3'd1; opa = P2; opb = SN;
    rst = 1'b1;
    @(posedge clk); #1;
    check("R1 reset clears", {fflags, result}, 37'b0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_minmax_plain;
    step("R6 min pos", 3'd0, P2, P1);
    step("R6 max mixed sign", 3'd1, N1, P1);
    step("R6 min neg", 3'd0, N1, N2);
    step("R6 minp same as min", 3'd2, N1, N2);
    step("R6 maxp inf", 3'd3, PINF, P2);
    step("R6 min -inf", 3'd0, P1, NINF);
  endtask

  task automatic t_zeros;
    step("R6 min +0,-0", 3'd0, PZ, NZ);
    step("R6 max -0,+0", 3'd1, NZ, PZ);
    step("R6 minp -0,+0", 3'd2, NZ, PZ);
    step("R8 le +0,-0 equal", 3'd4, PZ, NZ);
    step("R8 lt -0,+0 not less", 3'd5, NZ, PZ);
  endtask

  task automatic t_nan_minmax;
    step("R4 min one qnan", 3'd0, QN2, P1);
    step("R4 max one qnan b", 3'd1, N2, QN);
    step("R4 both nan canon", 3'd1, QN2, QN);
    step("R7 min snan flags+value", 3'd0, SN, P2);
    step("R5 minp qnan canon", 3'd2, P1, QN2);
    step("R5 R7 maxp snan canon+nv", 3'd3, SN, N1);
  endtask

  task automatic t_compare;
    step("R8 le true", 3'd4, N1, P1);
    step("R8 lt false", 3'd5, P2, P1);
    step("R8 lt true neg", 3'd5, N2, N1);
    step("R8 le equal", 3'd4, P2, P2);
    step("R8 ltq true", 3'd7, P1, P2);
    step("R8 leq false", 3'd6, PINF, P2);
  endtask

  task automatic t_compare_nan;
    step("R9 le qnan nv", 3'd4, QN, P1);
    step("R9 lt snan nv", 3'd5, P1, SN);
    step("R10 leq qnan quiet", 3'd6, QN2, P1);
    step("R10 ltq qnan quiet", 3'd7, P1, QN);
    step("R10 ltq snan nv", 3'd7, SN, P1);
  endtask

  task automatic t_back_to_back;
    step("R2 b2b maxp snan", 3'd3, SN, P1);
    step("R2 b2b lt after", 3'd5, P1, P2);
    step("R3 R11 min after", 3'd0, P2, N2);
    step("R2 b2b ltq", 3'd7, N1, N1);
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset;
    t_minmax_plain;
    t_zeros;
    t_nan_minmax;
    t_compare;
    t_compare_nan;
    t_back_to_back;
    t_reset;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule